// File: doc/BRIEF.md
# Direct-Mapped Address Translation Buffer

This block turns a 32-bit virtual address into a physical address for pages of 8 KB. The low 13 address bits are the byte offset inside a page and pass through unchanged. The upper 19 bits are the virtual page number. The page number is split in two: its low 6 bits select one of 64 table slots, and its high 13 bits are compared against the tag held in that slot. Each slot holds a valid flag, the tag, a 19-bit physical page number and five permission and attribute flags.

A lookup is purely combinational. In the same cycle as the request, the block reports a hit or a miss, the physical address, a permission fault and whether the page may be cached. A refill agent or software loads a slot, or invalidates it, through a write port that takes effect on the clock edge. A flush input empties the whole table in one cycle. Page-table walking and the cache itself live outside this block.

Top module: `dtlb_direct`

## Requirements
- R1: After reset every slot is invalid, so every requested lookup misses.
- R2: A requested lookup hits when the slot chosen by vaddr[18:13] is valid and its stored tag equals vaddr[31:19]. The result appears combinationally, in the same cycle as the request.
- R3: On a hit with no fault, the physical address is the stored page number followed by vaddr[12:0].
- R4: A requested lookup that does not hit raises miss, keeps hit low and drives the physical address to zero. Hit and miss are never high together.
- R5: Attribute bit 0 allows user reads and bit 1 user writes. Bit 2 allows supervisor reads and bit 3 supervisor writes. On a hit whose flags deny the current access type and privilege, fault is raised, and the physical address and the cacheable flag are forced to zero.
- R6: A write with the valid flag set stores the index, tag, page number and attributes into the addressed slot at the clock edge. It is visible from the next cycle, and no other slot changes.
- R7: A write with the valid flag clear makes the addressed slot miss from the next cycle, and leaves the other slots untouched.
- R8: Flush clears every valid flag at one clock edge. A write presented in the same cycle as a flush is dropped.
- R9: Without a lookup request, hit, miss and fault are all low and the physical address is zero.
- R10: Attribute bit 4 marks a page as cacheable. The cacheable output shows it on a hit with no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the table |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_is_write | input | 1 | Access is a store |
| lk_is_super | input | 1 | Access is made in supervisor mode |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | No translation found |
| lk_fault | output | 1 | Hit, but the access is not permitted |
| lk_paddr | output | 32 | Physical address, zero unless the hit is permitted |
| lk_cacheable | output | 1 | Page may be cached |
| wr_en | input | 1 | Write one slot |
| wr_idx | input | 6 | Slot index |
| wr_valid | input | 1 | Valid flag to store (0 invalidates the slot) |
| wr_tag | input | 13 | Tag to store |
| wr_ppn | input | 19 | Physical page number to store |
| wr_attr | input | 5 | Attribute flags to store |
| flush | input | 1 | Invalidate all slots |

## Verification
The assertions check on every cycle that hit and miss are mutually exclusive and that an idle port stays quiet. They also check that a fault never leaks an address or the cacheable flag, that a flush leaves no valid slot, that a write lands exactly in its slot and that the valid flags hold still without a write. The scenarios in the bench show what no per-cycle property can: the exact translated addresses, the decoding of each permission bit for each mode, tag and index aliasing between slots, invalidation of one slot, and the rule that a flush wins over a simultaneous write.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W       = 32;
    localparam int PAGE_OFF_W = 13;
    localparam int IDX_W      = 6;
    localparam int PPN_W      = 19;
    localparam int ATTR_W     = 5;
    localparam int ENTRIES    = 1 << IDX_W;
    localparam int VPN_W      = VA_W - PAGE_OFF_W;
    localparam int TAG_W      = VPN_W - IDX_W;
    localparam int PA_W       = PPN_W + PAGE_OFF_W;

    localparam int A_USER_RD  = 0;
    localparam int A_USER_WR  = 1;
    localparam int A_SUP_RD   = 2;
    localparam int A_SUP_WR   = 3;
    localparam int A_CACHE    = 4;

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [PPN_W-1:0]  ppn;
        logic [ATTR_W-1:0] attr;
    } tlb_entry_t;
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
    import tlb_pkg::*;
#(
    parameter int N_ENT = ENTRIES,
    parameter int IW    = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  tlb_entry_t    wr_entry,
    input  logic          flush,
    input  logic [IW-1:0] rd_idx,
    output tlb_entry_t    rd_entry
);
    typedef struct packed {
        tlb_entry_t [N_ENT-1:0] ent;
    } store_t;

    store_t           state_d, state_q;
    logic [N_ENT-1:0] valid_vec;

    always_comb begin
        state_d = state_q;
        if (flush) begin
            for (int i = 0; i < N_ENT; i++) begin
                state_d.ent[i].valid = 1'b0;
            end
        end else if (wr_en) begin
            state_d.ent[wr_idx] = wr_entry;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rd_entry = state_q.ent[rd_idx];

    for (genvar g = 0; g < N_ENT; g++) begin : g_valid
        assign valid_vec[g] = state_q.ent[g].valid;
    end

    // R8: after a flush edge no slot is valid
    p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_vec == '0));

    // R6: a write lands whole in the addressed slot
    p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush) |=> (state_q.ent[$past(wr_idx)] == $past(wr_entry)));

    // R6, R7: valid flags move only on a write or a flush
    p_valid_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !flush) |=> $stable(valid_vec));
endmodule

// File: rtl/tlb_tag_match.sv
module tlb_tag_match
    import tlb_pkg::*;
#(
    parameter int TW = TAG_W
) (
    input  logic          req,
    input  logic [TW-1:0] tag,
    input  tlb_entry_t    entry,
    output logic          hit,
    output logic          miss
);
    logic match;

    always_comb begin
        match = entry.valid && (entry.tag == tag);
        hit   = req && match;
        miss  = req && !match;
    end
endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check
    import tlb_pkg::*;
#(
    parameter int AW = ATTR_W
) (
    input  logic [AW-1:0] attr,
    input  logic          is_write,
    input  logic          is_super,
    output logic          allow
);
    always_comb begin
        unique case ({is_super, is_write})
            2'b00:   allow = attr[A_USER_RD];
            2'b01:   allow = attr[A_USER_WR];
            2'b10:   allow = attr[A_SUP_RD];
            default: allow = attr[A_SUP_WR];
        endcase
    end
endmodule

// File: rtl/dtlb_direct.sv
module dtlb_direct
    import tlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic              lk_is_write,
    input  logic              lk_is_super,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic              lk_fault,
    output logic [VA_W-1:0]   lk_paddr,
    output logic              lk_cacheable,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic [ATTR_W-1:0] wr_attr,
    input  logic              flush
);
    localparam int PAD_W = VA_W - PA_W;

    tlb_entry_t             wr_entry, rd_entry;
    logic [IDX_W-1:0]       lk_idx;
    logic [TAG_W-1:0]       lk_tag;
    logic [PAGE_OFF_W-1:0]  lk_off;
    logic                   hit, miss, allow, grant;

    always_comb begin
        wr_entry = '{valid: wr_valid, tag: wr_tag, ppn: wr_ppn, attr: wr_attr};
        lk_off   = lk_vaddr[PAGE_OFF_W-1:0];
        lk_idx   = lk_vaddr[PAGE_OFF_W +: IDX_W];
        lk_tag   = lk_vaddr[VA_W-1 -: TAG_W];
    end

    tlb_entry_store #(.N_ENT(ENTRIES), .IW(IDX_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_entry (wr_entry),
        .flush    (flush),
        .rd_idx   (lk_idx),
        .rd_entry (rd_entry)
    );

    tlb_tag_match #(.TW(TAG_W)) u_match (
        .req   (lk_req),
        .tag   (lk_tag),
        .entry (rd_entry),
        .hit   (hit),
        .miss  (miss)
    );

    tlb_perm_check #(.AW(ATTR_W)) u_perm (
        .attr     (rd_entry.attr),
        .is_write (lk_is_write),
        .is_super (lk_is_super),
        .allow    (allow)
    );

    always_comb begin
        grant        = hit && allow;
        lk_hit       = hit;
        lk_miss      = miss;
        lk_fault     = hit && !allow;
        lk_cacheable = grant && rd_entry.attr[A_CACHE];
        if (grant) lk_paddr = {{PAD_W{1'b0}}, rd_entry.ppn, lk_off};
        else       lk_paddr = '0;
    end

    // R4: hit and miss never together
    p_hit_miss_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_miss));

    // R9: idle port is quiet
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |-> (!lk_hit && !lk_miss && !lk_fault && lk_paddr == '0));

    // R5: a fault leaks neither address nor cacheable flag
    p_fault_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> (lk_hit && lk_paddr == '0 && !lk_cacheable));

    // R3: page offset passes through on a granted hit
    p_offset_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && !lk_fault) |-> (lk_paddr[PAGE_OFF_W-1:0] == lk_vaddr[PAGE_OFF_W-1:0]));

    // R4: a miss returns no address
    p_miss_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss |-> (lk_paddr == '0 && !lk_fault && !lk_cacheable));
endmodule

// File: tb/tb_dtlb_direct.sv
module tb_dtlb_direct;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_is_write = 1'b0;
    logic        lk_is_super = 1'b0;
    logic        lk_hit, lk_miss, lk_fault, lk_cacheable;
    logic [31:0] lk_paddr;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic        wr_valid = 1'b0;
    logic [12:0] wr_tag = '0;
    logic [18:0] wr_ppn = '0;
    logic [4:0]  wr_attr = '0;
    logic        flush = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dtlb_direct dut (.*);

    function automatic logic [31:0] va(input logic [12:0] tag, input logic [5:0] idx,
                                       input logic [12:0] off);
        return {tag, idx, off};
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] idx, input logic v, input logic [12:0] tag,
                      input logic [18:0] ppn, input logic [4:0] attr, input logic fl);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_valid = v; wr_tag = tag; wr_ppn = ppn;
        wr_attr = attr; flush = fl;
        @(negedge clk);
        wr_en = 1'b0; flush = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    // drive a lookup and expect {hit,miss,fault,cacheable} and paddr
    task automatic look(input string req, input logic [31:0] a, input logic w, input logic s,
                        input logic [3:0] exp_flags, input logic [31:0] exp_pa);
        lk_req = 1'b1; lk_vaddr = a; lk_is_write = w; lk_is_super = s;
        #1;
        check(req, {28'd0, lk_hit, lk_miss, lk_fault, lk_cacheable}, {28'd0, exp_flags});
        check(req, lk_paddr, exp_pa);
        lk_req = 1'b0;
        #0;
    endtask

    task automatic t_reset();
        look("R1", va(13'h0000, 6'd0, 13'h0), 1'b0, 1'b0, 4'b0100, 32'h0);
        look("R1", va(13'h1ABC, 6'd5, 13'h10), 1'b0, 1'b1, 4'b0100, 32'h0);
    endtask

    task automatic t_idle();
        lk_req = 1'b0; lk_vaddr = va(13'h1ABC, 6'd5, 13'h0F3);
        #1;
        check("R9", {29'd0, lk_hit, lk_miss, lk_fault}, 32'd0);
        check("R9", lk_paddr, 32'h0);
    endtask

    task automatic t_basic();
        wr(6'd5, 1'b1, 13'h1ABC, 19'h12345, 5'b11111, 1'b0);
        look("R2 R3 R10", va(13'h1ABC, 6'd5, 13'h0F3), 1'b0, 1'b0, 4'b1001,
             {19'h12345, 13'h0F3});
        look("R4 tag mismatch", va(13'h1ABD, 6'd5, 13'h0F3), 1'b0, 1'b0, 4'b0100, 32'h0);
        look("R4 index mismatch", va(13'h1ABC, 6'd6, 13'h0F3), 1'b0, 1'b0, 4'b0100, 32'h0);
        t_idle();
    endtask

    task automatic t_edges();
        wr(6'd63, 1'b1, 13'h1FFF, 19'h7FFFF, 5'b10101, 1'b0);
        look("R2 R3 top slot", va(13'h1FFF, 6'd63, 13'h1FFF), 1'b0, 1'b1, 4'b1001,
             32'hFFFF_FFFF);
        wr(6'd0, 1'b1, 13'h0000, 19'h00001, 5'b00001, 1'b0);
        look("R2 R3 R10 slot zero", va(13'h0, 6'd0, 13'h0), 1'b0, 1'b0, 4'b1000, 32'h0000_2000);
    endtask

    task automatic t_perm();
        wr(6'd9, 1'b1, 13'h0042, 19'h00ABC, 5'b00101, 1'b0);
        look("R5 user read ok, R10 uncached", va(13'h42, 6'd9, 13'h4), 1'b0, 1'b0, 4'b1000,
             {19'h00ABC, 13'h4});
        look("R5 user write denied", va(13'h42, 6'd9, 13'h4), 1'b1, 1'b0, 4'b1010, 32'h0);
        look("R5 super read ok", va(13'h42, 6'd9, 13'h8), 1'b0, 1'b1, 4'b1000,
             {19'h00ABC, 13'h8});
        look("R5 super write denied", va(13'h42, 6'd9, 13'h8), 1'b1, 1'b1, 4'b1010, 32'h0);
        wr(6'd9, 1'b1, 13'h0042, 19'h00ABC, 5'b11010, 1'b0);
        look("R5 user read denied, cacheable hidden", va(13'h42, 6'd9, 13'h0), 1'b0, 1'b0,
             4'b1010, 32'h0);
        look("R5 user write ok", va(13'h42, 6'd9, 13'h0), 1'b1, 1'b0, 4'b1001,
             {19'h00ABC, 13'h0});
        look("R5 super read denied", va(13'h42, 6'd9, 13'h0), 1'b0, 1'b1, 4'b1010, 32'h0);
        look("R5 super write ok", va(13'h42, 6'd9, 13'h0), 1'b1, 1'b1, 4'b1001,
             {19'h00ABC, 13'h0});
    endtask

    task automatic t_isolation();
        wr(6'd7, 1'b1, 13'h0777, 19'h00777, 5'b11111, 1'b0);
        look("R6 neighbour kept", va(13'h1ABC, 6'd5, 13'h1), 1'b0, 1'b0, 4'b1001,
             {19'h12345, 13'h1});
        wr(6'd5, 1'b1, 13'h1ABC, 19'h54321, 5'b11111, 1'b0);
        look("R6 overwrite", va(13'h1ABC, 6'd5, 13'h1), 1'b0, 1'b0, 4'b1001,
             {19'h54321, 13'h1});
        look("R6 slot 7", va(13'h0777, 6'd7, 13'h2), 1'b0, 1'b0, 4'b1001, {19'h00777, 13'h2});
    endtask

    task automatic t_invalidate();
        wr(6'd5, 1'b0, 13'h1ABC, 19'h54321, 5'b11111, 1'b0);
        look("R7 slot gone", va(13'h1ABC, 6'd5, 13'h1), 1'b0, 1'b0, 4'b0100, 32'h0);
        look("R7 other kept", va(13'h0777, 6'd7, 13'h2), 1'b0, 1'b0, 4'b1001,
             {19'h00777, 13'h2});
    endtask

    task automatic t_flush();
        do_flush();
        look("R8 slot 7 cleared", va(13'h0777, 6'd7, 13'h2), 1'b0, 1'b0, 4'b0100, 32'h0);
        look("R8 slot 63 cleared", va(13'h1FFF, 6'd63, 13'h0), 1'b0, 1'b1, 4'b0100, 32'h0);
        wr(6'd12, 1'b1, 13'h0123, 19'h00456, 5'b11111, 1'b1);
        look("R8 write dropped by flush", va(13'h0123, 6'd12, 13'h0), 1'b0, 1'b0, 4'b0100, 32'h0);
        wr(6'd12, 1'b1, 13'h0123, 19'h00456, 5'b11111, 1'b0);
        look("R6 write after flush", va(13'h0123, 6'd12, 13'h5), 1'b0, 1'b0, 4'b1001,
             {19'h00456, 13'h5});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle();
        t_basic();
        t_edges();
        t_perm();
        t_isolation();
        t_invalidate();
        t_flush();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule